// File: doc/BRIEF.md
# Byte-Merging ECC Granule Controller

This block owns a small array of 16-bit data granules and keeps every granule protected by a 6-bit single-error-correct, double-error-detect check field. A client issues reads and writes through one port, and each write carries a two-bit byte-lane enable. When a write covers the whole granule, the data is encoded and stored in one cycle. When a write covers only one byte, the controller reads the granule, corrects it if needed, merges the new byte and re-encodes the result. This read-merge-write sequence spans three cycles, and the controller signals busy for the last two of them.

Reads return corrected data one cycle after they are accepted. Every decode raises one of two alarms: a correctable alarm for a repaired single-bit flip, or an uncorrectable alarm for a double-bit flip. The uncorrectable alarm is the critical one. If the read phase of a byte write finds an uncorrectable granule, the write phase is skipped and the granule keeps its old content. After reset every granule holds a deliberately inconsistent check field, so a granule that has never been written always decodes as uncorrectable. A fault-injection mask that is applied on full writes lets the stored codeword be corrupted on purpose.

Top module: `ecc_granule_rmw`

## Requirements
- R1: A write with `reqByteEn` = 2'b11 accepted while idle stores `reqWdata` and fresh check bits in that same clock edge. A later read of that address returns the value with both alarms low.
- R2: A read accepted while idle gives `rspValid` high for exactly one cycle, in the cycle after acceptance, with `rspData` carrying the corrected granule.
- R3: A single flipped data bit in a stored granule is corrected in `rspData`, and `alarmCe` pulses together with `rspValid`.
- R4: Two flipped bits in a stored granule raise `alarmUce` with `rspValid`, and `alarmCe` stays low.
- R5: The stored codeword is 22 bits: data in bits [15:0] and the 6-bit check field in bits [21:16]. The check field holds five position-parity bits and one overall parity bit. On a full write, `injMask` is XORed bit-for-bit onto this codeword. A single flip inside the check field is also reported through `alarmCe`, and the returned data is intact.
- R6: A write with `reqByteEn` of 2'b01 (low byte, bits [7:0]) or 2'b10 (high byte, bits [15:8]) holds `busy` high for the two cycles after acceptance. The unselected byte keeps its previous (corrected) value.
- R7: If the read phase of a byte write decodes an uncorrectable granule, `alarmUce` pulses in the cycle after that phase. `busy` drops in the same cycle, and the granule is left unchanged.
- R8: After reset, every granule decodes as uncorrectable, both on a plain read and in the read phase of a byte write.
- R9: A correctable error found in the read phase of a byte write pulses `alarmCe`. The write still completes, and the merge uses the corrected data.
- R10: Requests presented while `busy` is high are ignored: they produce no response and change no granule.
- R11: A write with `reqByteEn` = 2'b00 changes no granule and does not assert `busy`.
- R12: `alarmCe` and `alarmUce` are never high together. Either alarm is high only with a read response or in the cycle after a byte write's read phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Granule index |
| reqByteEn | input | 2 | Byte-lane enables for writes |
| reqWdata | input | 16 | Write data |
| injMask | input | 22 | Codeword flip mask applied on full writes |
| busy | output | 1 | Byte write sequence in progress |
| rspValid | output | 1 | Read data valid |
| rspData | output | 16 | Corrected read data |
| alarmCe | output | 1 | Correctable error pulse |
| alarmUce | output | 1 | Uncorrectable error pulse |

## Verification
Two pairs of functions can collide. The first pair is the error decode and the write commit within one byte write. A byte write is aimed at a granule that was first stored with one or two injected flips, or at a granule that was never written. The bench then checks the alarm in the cycle after the read phase, checks whether `busy` is still high, and reads the granule back to see whether the merge happened and used corrected data. The second pair is a new request and the ongoing sequence. A full write and a read are issued while `busy` is high, and the bench checks that no response appears and that the merged value survives.

// File: rtl/ecc_rmw_pkg.sv
package ecc_rmw_pkg;

  localparam int DATA_W = 16;
  localparam int CHK_W  = 6;
  localparam int CW_W   = DATA_W + CHK_W;
  localparam int LANES  = DATA_W / 8;
  localparam int HPOS   = 21;  // highest Hamming position used

  typedef struct packed {
    logic rdFire;
    logic fullWr;
    logic rmwCapture;
    logic rmwCheck;
    logic rmwCommit;
  } ctrlStrobe_t;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              ce;
    logic              uce;
  } decRes_t;

  function automatic logic [CHK_W-1:0] eccEncode(input logic [DATA_W-1:0] d);
    logic [31:0]      cw;
    logic [CHK_W-1:0] c;
    int               k;
    cw = '0;
    c  = '0;
    k  = 0;
    for (int pos = 1; pos <= HPOS; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        cw[pos] = d[k];
        k++;
      end
    end
    for (int j = 0; j < CHK_W - 1; j++) begin
      for (int pos = 1; pos <= HPOS; pos++) begin
        if (pos[j]) c[j] = c[j] ^ cw[pos];
      end
    end
    c[CHK_W-1] = (^d) ^ (^c[CHK_W-2:0]);
    return c;
  endfunction

  function automatic decRes_t eccDecode(input logic [DATA_W-1:0] d,
                                        input logic [CHK_W-1:0] c);
    logic [31:0] cw;
    logic [4:0]  syn;
    logic        oddErr;
    int          k;
    decRes_t     r;
    cw  = '0;
    syn = '0;
    k   = 0;
    for (int pos = 1; pos <= HPOS; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        cw[pos] = d[k];
        k++;
      end
    end
    for (int j = 0; j < CHK_W - 1; j++) cw[1 << j] = c[j];
    for (int j = 0; j < CHK_W - 1; j++) begin
      for (int pos = 1; pos <= HPOS; pos++) begin
        if (pos[j]) syn[j] = syn[j] ^ cw[pos];
      end
    end
    oddErr = (^cw) ^ c[CHK_W-1];
    r.ce  = 1'b0;
    r.uce = 1'b0;
    if (syn == 5'd0) begin
      r.ce = oddErr;                      // flip in overall parity bit
    end else if (!oddErr) begin
      r.uce = 1'b1;                       // even flip count, nonzero syndrome
    end else if (int'(syn) > HPOS) begin
      r.uce = 1'b1;                       // syndrome outside the codeword
    end else begin
      cw[syn] = ~cw[syn];
      r.ce    = 1'b1;
    end
    k = 0;
    r.data = '0;
    for (int pos = 1; pos <= HPOS; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        r.data[k] = cw[pos];
        k++;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/ecc_rmw_seq.sv
module ecc_rmw_seq
  import ecc_rmw_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [LANES-1:0] reqByteEn,
  input  logic             decUce,
  output ctrlStrobe_t      strb,
  output logic             busy
);

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} seqState_t;

  seqState_t state, stateNext;
  logic      accept;
  logic      fullLanes;
  logic      someLanes;

  assign accept    = (state == ST_IDLE) && reqValid;
  assign fullLanes = &reqByteEn;
  assign someLanes = |reqByteEn;

  always_comb begin
    strb.rdFire     = accept && !reqWrite;
    strb.fullWr     = accept && reqWrite && fullLanes;
    strb.rmwCapture = accept && reqWrite && someLanes && !fullLanes;
    strb.rmwCheck   = (state == ST_READ);
    strb.rmwCommit  = (state == ST_WRITE);
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (strb.rmwCapture) stateNext = ST_READ;
      ST_READ:  stateNext = decUce ? ST_IDLE : ST_WRITE;
      ST_WRITE: stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy = (state != ST_IDLE);

  // R6: a commit is always preceded by a read phase
  p_commit_after_check_r6 : assert property (@(posedge clk) disable iff (!rstN)
    strb.rmwCommit |-> $past(strb.rmwCheck));

endmodule

// File: rtl/ecc_rmw_dpath.sv
module ecc_rmw_dpath
  import ecc_rmw_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LANES-1:0]  reqByteEn,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [CW_W-1:0]   injMask,
  output logic              decUce,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              alarmCe,
  output logic              alarmUce
);

  localparam int DEPTH = 1 << ADDR_W;
  // Two position-parity bits set on zero data: syndrome 3, even flip count
  localparam logic [CHK_W-1:0] POISON_CHK = 6'b000011;

  logic [DATA_W-1:0] memData [DEPTH];
  logic [CHK_W-1:0]  memChk  [DEPTH];

  logic [ADDR_W-1:0] latAddr;
  logic [LANES-1:0]  latBe;
  logic [DATA_W-1:0] latWdata;
  logic [DATA_W-1:0] mergeQ;
  logic [DATA_W-1:0] mergeNext;
  logic [ADDR_W-1:0] rdAddr;
  logic [CW_W-1:0]   fullCw;
  decRes_t           dec;

  assign rdAddr = strb.rmwCheck ? latAddr : reqAddr;
  assign dec    = eccDecode(memData[rdAddr], memChk[rdAddr]);
  assign decUce = dec.uce;
  assign fullCw = {eccEncode(reqWdata), reqWdata} ^ injMask;

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    assign mergeNext[8*ln +: 8] = latBe[ln] ? latWdata[8*ln +: 8] : dec.data[8*ln +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latAddr  <= '0;
      latBe    <= '0;
      latWdata <= '0;
      mergeQ   <= '0;
    end else begin
      if (strb.rmwCapture) begin
        latAddr  <= reqAddr;
        latBe    <= reqByteEn;
        latWdata <= reqWdata;
      end
      if (strb.rmwCheck) mergeQ <= mergeNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        memData[i] <= '0;
        memChk[i]  <= POISON_CHK;
      end
    end else if (strb.fullWr) begin
      memData[reqAddr] <= fullCw[DATA_W-1:0];
      memChk[reqAddr]  <= fullCw[CW_W-1:DATA_W];
    end else if (strb.rmwCommit) begin
      memData[latAddr] <= mergeQ;
      memChk[latAddr]  <= eccEncode(mergeQ);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
      alarmCe  <= 1'b0;
      alarmUce <= 1'b0;
    end else begin
      rspValid <= strb.rdFire;
      if (strb.rdFire) rspData <= dec.data;
      alarmCe  <= (strb.rdFire || strb.rmwCheck) && dec.ce;
      alarmUce <= (strb.rdFire || strb.rmwCheck) && dec.uce;
    end
  end

  // R7: an uncorrectable read phase is never followed by a commit
  p_abort_no_commit_r7 : assert property (@(posedge clk) disable iff (!rstN)
    (strb.rmwCheck && decUce) |=> !strb.rmwCommit);

  // R12: alarms are exclusive
  p_alarm_exclusive_r12 : assert property (@(posedge clk) disable iff (!rstN)
    !(alarmCe && alarmUce));

  // R12: alarms only accompany a response or follow a read phase
  p_alarm_context_r12 : assert property (@(posedge clk) disable iff (!rstN)
    (alarmCe || alarmUce) |-> (rspValid || $past(strb.rmwCheck)));

endmodule

// File: rtl/ecc_granule_rmw.sv
module ecc_granule_rmw
  import ecc_rmw_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqByteEn,
  input  logic [15:0]       reqWdata,
  input  logic [21:0]       injMask,
  output logic              busy,
  output logic              rspValid,
  output logic [15:0]       rspData,
  output logic              alarmCe,
  output logic              alarmUce
);

  ctrlStrobe_t strb;
  logic        decUce;

  ecc_rmw_seq u_seq (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .reqByteEn (reqByteEn),
    .decUce    (decUce),
    .strb      (strb),
    .busy      (busy)
  );

  ecc_rmw_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .reqAddr   (reqAddr),
    .reqByteEn (reqByteEn),
    .reqWdata  (reqWdata),
    .injMask   (injMask),
    .decUce    (decUce),
    .rspValid  (rspValid),
    .rspData   (rspData),
    .alarmCe   (alarmCe),
    .alarmUce  (alarmUce)
  );

  // R10: a read presented while busy yields no response
  p_busy_read_ignored_r10 : assert property (@(posedge clk) disable iff (!rstN)
    (busy && reqValid && !reqWrite) |=> !rspValid);

  // R2: a response never lasts two cycles without a second read
  p_rsp_single_r2 : assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !(reqValid && !reqWrite && !busy)) |=> !rspValid);

endmodule

// File: tb/ecc_granule_rmw_bench.sv
`timescale 1ns/1ps
module ecc_granule_rmw_bench;

  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [1:0]    reqByteEn = '0;
  logic [15:0]   reqWdata = '0;
  logic [21:0]   injMask = '0;
  logic          busy, rspValid, alarmCe, alarmUce;
  logic [15:0]   rspData;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ecc_granule_rmw #(.ADDR_W(AW)) u_ecc_granule_rmw (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqByteEn(reqByteEn), .reqWdata(reqWdata),
    .injMask(injMask), .busy(busy), .rspValid(rspValid), .rspData(rspData),
    .alarmCe(alarmCe), .alarmUce(alarmUce)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idleBus();
    reqValid = 1'b0; reqWrite = 1'b0; reqByteEn = '0; injMask = '0;
  endtask

  // Read: accept at next posedge, sample at the following negedge
  task automatic doRead(input logic [AW-1:0] a, input logic [15:0] expD,
                        input bit expCe, input bit expUce, input string req);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = a;
    @(negedge clk);
    idleBus();
    check(rspValid === 1'b1, req, {31'd0, rspValid}, 32'd1);
    if (!expUce) check(rspData === expD, req, {16'd0, rspData}, {16'd0, expD});
    check(alarmCe === expCe, req, {31'd0, alarmCe}, {31'd0, expCe});
    check(alarmUce === expUce, req, {31'd0, alarmUce}, {31'd0, expUce});
    @(negedge clk);
    check(rspValid === 1'b0, "R2", {31'd0, rspValid}, 32'd0);
  endtask

  task automatic doFull(input logic [AW-1:0] a, input logic [15:0] d,
                        input logic [21:0] mask);
    reqValid = 1'b1; reqWrite = 1'b1; reqByteEn = 2'b11; reqAddr = a;
    reqWdata = d; injMask = mask;
    @(negedge clk);
    idleBus();
    check(busy === 1'b0, "R1", {31'd0, busy}, 32'd0);
  endtask

  task automatic doByte(input logic [AW-1:0] a, input logic [1:0] be,
                        input logic [15:0] d, input bit expCe, input bit expUce,
                        input string req);
    reqValid = 1'b1; reqWrite = 1'b1; reqByteEn = be; reqAddr = a; reqWdata = d;
    @(negedge clk);
    idleBus();
    check(busy === 1'b1, "R6", {31'd0, busy}, 32'd1);
    @(negedge clk);
    check(alarmCe === expCe, req, {31'd0, alarmCe}, {31'd0, expCe});
    check(alarmUce === expUce, req, {31'd0, alarmUce}, {31'd0, expUce});
    check(busy === !expUce, req, {31'd0, busy}, {31'd0, !expUce});
    if (!expUce) begin
      @(negedge clk);
      check(busy === 1'b0, "R6", {31'd0, busy}, 32'd0);
    end
  endtask

  task automatic testReset();
    check(busy === 1'b0 && rspValid === 1'b0, "R2",
          {30'd0, busy, rspValid}, 32'd0);
    check(alarmCe === 1'b0 && alarmUce === 1'b0, "R12",
          {30'd0, alarmCe, alarmUce}, 32'd0);
  endtask

  task automatic testUninit();
    doRead(4'd7, 16'h0000, 1'b0, 1'b1, "R8");            // never written
    doByte(4'd8, 2'b01, 16'h00AA, 1'b0, 1'b1, "R8");     // byte write to fresh granule
    doRead(4'd8, 16'h0000, 1'b0, 1'b1, "R7");            // still poisoned
  endtask

  task automatic testFullAndCorrect();
    doFull(4'd1, 16'hA5C3, '0);
    doRead(4'd1, 16'hA5C3, 1'b0, 1'b0, "R1");
    doFull(4'd2, 16'h1234, 22'h000020);                   // data bit 5 flipped
    doRead(4'd2, 16'h1234, 1'b1, 1'b0, "R3");
    doFull(4'd3, 16'hBEEF, 22'h040000);                   // check bit 2 flipped
    doRead(4'd3, 16'hBEEF, 1'b1, 1'b0, "R5");
    doFull(4'd4, 16'hFFFF, 22'h200000);                   // overall parity flipped
    doRead(4'd4, 16'hFFFF, 1'b1, 1'b0, "R5");
    doFull(4'd5, 16'h0F0F, 22'h000201);                   // data bits 0 and 9
    doRead(4'd5, 16'h0000, 1'b0, 1'b1, "R4");
  endtask

  task automatic testByteMerge();
    doByte(4'd1, 2'b01, 16'h117E, 1'b0, 1'b0, "R6");
    doRead(4'd1, 16'hA57E, 1'b0, 1'b0, "R6");
    doByte(4'd1, 2'b10, 16'h3C22, 1'b0, 1'b0, "R6");
    doRead(4'd1, 16'h3C7E, 1'b0, 1'b0, "R6");
    // granule 5 holds a double error: write abandoned, still uncorrectable
    doByte(4'd5, 2'b10, 16'h9900, 1'b0, 1'b1, "R7");
    doRead(4'd5, 16'h0000, 1'b0, 1'b1, "R7");
    // granule 2 holds a single error in the low byte: merge uses corrected data
    doByte(4'd2, 2'b10, 16'hC300, 1'b1, 1'b0, "R9");
    doRead(4'd2, 16'hC334, 1'b0, 1'b0, "R9");
  endtask

  task automatic testBusyAndNoLane();
    doFull(4'd9, 16'h5555, '0);
    reqValid = 1'b1; reqWrite = 1'b1; reqByteEn = 2'b01; reqAddr = 4'd9;
    reqWdata = 16'h00AA;
    @(negedge clk);                                       // read phase now
    check(busy === 1'b1, "R10", {31'd0, busy}, 32'd1);
    reqByteEn = 2'b11; reqWdata = 16'hDEAD;               // full write while busy
    @(negedge clk);                                       // write phase now
    reqWrite = 1'b0;                                      // read while busy
    @(negedge clk);
    check(rspValid === 1'b0, "R10", {31'd0, rspValid}, 32'd0);
    idleBus();
    doRead(4'd9, 16'h55AA, 1'b0, 1'b0, "R10");
    reqValid = 1'b1; reqWrite = 1'b1; reqByteEn = 2'b00; reqAddr = 4'd9;
    reqWdata = 16'h0000;
    @(negedge clk);
    idleBus();
    check(busy === 1'b0, "R11", {31'd0, busy}, 32'd0);
    doRead(4'd9, 16'h55AA, 1'b0, 1'b0, "R11");
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testUninit();
    testFullAndCorrect();
    testByteMerge();
    testBusyAndNoLane();
    finishRun();
  end

  initial begin
    #(200000 * 4);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

endmodule